// File: doc/BRIEF.md
# Multi-Format Audio Serial Port

This block is the slave side of an audio serial link. An external device supplies the bit clock and the frame clock. Both arrive here as plain inputs that are sampled on the chip clock, and the block finds their edges itself. The block has three stereo playback lanes. Each lane turns its serial data into a pair of parallel 24-bit samples. When a full left/right pair has arrived, the lane raises a one-cycle strobe.

In the other direction, the block serialises a stereo 24-bit capture pair onto one output lane. A select input can hand that output lane to an auxiliary serial input, which is then passed through bit for bit.

The playback side and the capture side take their formats from separate inputs, and the two sets of formats differ. Playback accepts left-aligned, I2S and two right-aligned widths (20 and 24 bits). Capture offers left-aligned and I2S. Every frame is 64 bit clocks long, with 32 bit clocks per channel slot. Data is taken on the rising edge of the bit clock and driven after the falling edge.

Top module: `audio_serial_port`

## Requirements
- R1: After a synchronous active-low reset, all playback samples are zero, every valid strobe is low, and the output lane is low while the source select is low.
- R2: With `play_fmt` = 0 (left-aligned), the left sample is received while `lrck` is high. The MSB is taken on the first rising `bick` of the slot, and 24 bits follow, MSB first.
- R3: With `play_fmt` = 3 (I2S), the left sample is received while `lrck` is low. The MSB is taken on the second rising `bick` of the slot.
- R4: With `play_fmt` = 2 (right-aligned 24-bit), the left slot has `lrck` high and its 24 bits are taken on slot positions 8 to 31. The LSB falls on the last rising `bick` before the `lrck` edge.
- R5: With `play_fmt` = 1 (right-aligned 20-bit), the 20 bits are taken on slot positions 12 to 31 and are sign-extended to 24 bits.
- R6: Each lane pulses its `play_valid` bit high for exactly one clock cycle, once per frame, after the right sample that follows a left sample. The pulse comes one cycle after a rising `bick` is seen.
- R7: The three playback lanes use the shared clocks but decode their own data inputs independently.
- R8: With `cap_fmt` = 0 (left-aligned, left while `lrck` high), the output lane carries the capture sample MSB first, starting at slot position 0. Slot positions 24 to 31 are zero. The output changes only in the cycle after a falling `bick` is seen.
- R9: With `cap_fmt` = 1 (I2S, left while `lrck` low), the capture MSB is at slot position 1. Position 0 and positions 25 to 31 are zero.
- R10: The capture sample for a slot is taken when the slot starts. A change on `cap_left` or `cap_right` during the slot does not alter the bits sent in that slot.
- R11: While `src_sel` is high, `sdout` equals `aux_in`. While it is low, `sdout` carries the internal capture stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock used to oversample the serial clocks |
| rst_n | input | 1 | Synchronous active-low reset |
| bick | input | 1 | Serial bit clock from the link master |
| lrck | input | 1 | Frame (channel) clock from the link master |
| play_fmt | input | 2 | Playback format: 0 left-aligned, 1 right-aligned 20-bit, 2 right-aligned 24-bit, 3 I2S |
| cap_fmt | input | 1 | Capture format: 0 left-aligned, 1 I2S |
| src_sel | input | 1 | Output source: 0 internal capture, 1 auxiliary input |
| sdin | input | NUM_LANES | Serial playback data, one bit per lane |
| aux_in | input | 1 | Auxiliary serial data passed to the output lane |
| cap_left | input | WORD_W | Left capture sample |
| cap_right | input | WORD_W | Right capture sample |
| sdout | output | 1 | Serial output lane |
| play_left | output | NUM_LANES*WORD_W | Left playback samples, lane k at bits k*WORD_W upward |
| play_right | output | NUM_LANES*WORD_W | Right playback samples, same packing |
| play_valid | output | NUM_LANES | One-cycle strobe per lane on a completed pair |

## Verification
The bench uses the default parameters: three lanes, 24-bit words, 32-bit slots and a 20-bit short word. This places both right-aligned widths at their real slot offsets of 8 and 12. It also makes the sign bit of the short word land exactly on bit 19. With three lanes, lane-specific data patterns can show any crosstalk between lanes. Combining each playback format with each capture format checks that the two sides choose their left slot from the `lrck` polarity independently.

// File: rtl/asp_pkg.sv
// Shared definitions for the audio serial port.
// Assumes: the playback format codes match the play_fmt port encoding.
package asp_pkg;
    typedef enum logic [1:0] {
        PF_LEFT   = 2'd0,
        PF_RJ20   = 2'd1,
        PF_RJ24   = 2'd2,
        PF_I2S    = 2'd3
    } play_fmt_e;
endpackage

// File: rtl/asp_frame_timer.sv
// Finds bit-clock edges by oversampling and tracks the bit position in the slot.
// Assumes: bick and lrck are synchronous to clk and each stays at a level for at
// least one clk period; lrck changes together with a falling bick.
module asp_frame_timer #(
    parameter int SLOT_W = 32,
    localparam int PW = $clog2(SLOT_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bick,
    input  logic          lrck,
    output logic          bick_rise,
    output logic          bick_fall,
    output logic [PW-1:0] pos
);
    logic          bick_q;
    logic          lrck_r;
    logic [PW-1:0] pos_q;

    assign bick_rise = bick & ~bick_q;
    assign bick_fall = ~bick & bick_q;
    // Position of the current bit: 0 right after an lrck change, else one past the last
    assign pos = (lrck != lrck_r) ? '0 : pos_q + PW'(1);

    // Keep the previous bick and, on each rising edge, the lrck level and position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bick_q <= 1'b0;
            lrck_r <= 1'b0;
            pos_q  <= '1;
        end else begin
            bick_q <= bick;
            if (bick_rise) begin
                lrck_r <= lrck;
                pos_q  <= pos;
            end
        end
    end
endmodule

// File: rtl/asp_rx_lane.sv
// One playback lane: shifts in serial data according to the playback format and
// stores a left and right sample at the end of each slot.
// Assumes: 32-position slots driven by asp_frame_timer; SHORT_W <= WORD_W <= SLOT_W.
module asp_rx_lane
    import asp_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int SHORT_W = 20,
    parameter int SLOT_W  = 32,
    localparam int PW = $clog2(SLOT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bick_rise,
    input  logic [PW-1:0]     pos,
    input  logic              lrck,
    input  play_fmt_e         fmt,
    input  logic              sdin,
    output logic [WORD_W-1:0] left_q,
    output logic [WORD_W-1:0] right_q,
    output logic              valid_q
);
    localparam logic [PW:0] FIRST_RJ24 = (PW+1)'(SLOT_W - WORD_W);
    localparam logic [PW:0] FIRST_RJ20 = (PW+1)'(SLOT_W - SHORT_W);
    localparam logic [PW:0] LEN_FULL   = (PW+1)'(WORD_W);
    localparam logic [PW:0] LEN_SHORT  = (PW+1)'(SHORT_W);

    logic [WORD_W-1:0] sh_q, sh_nxt, word;
    logic [PW:0]       first, len, pos_x;
    logic              is_left, take, slot_end, have_left;

    // Decode the data window and channel for the selected format
    always_comb begin
        pos_x   = {1'b0, pos};
        is_left = (fmt == PF_I2S) ? ~lrck : lrck;
        case (fmt)
            PF_LEFT: first = '0;
            PF_I2S:  first = (PW+1)'(1);
            PF_RJ24: first = FIRST_RJ24;
            default: first = FIRST_RJ20;
        endcase
        len      = (fmt == PF_RJ20) ? LEN_SHORT : LEN_FULL;
        take     = bick_rise && (pos_x >= first) && (pos_x < first + len);
        sh_nxt   = take ? {sh_q[WORD_W-2:0], sdin} : sh_q;
        word     = (fmt == PF_RJ20)
                 ? {{(WORD_W-SHORT_W){sh_nxt[SHORT_W-1]}}, sh_nxt[SHORT_W-1:0]}
                 : sh_nxt;
        slot_end = bick_rise && (pos == PW'(SLOT_W - 1));
    end

    // Shift data, store a sample at each slot end, strobe after a left/right pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q      <= '0;
            left_q    <= '0;
            right_q   <= '0;
            have_left <= 1'b0;
            valid_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            sh_q    <= sh_nxt;
            if (slot_end) begin
                if (is_left) begin
                    left_q    <= word;
                    have_left <= 1'b1;
                end else begin
                    right_q   <= word;
                    valid_q   <= have_left;
                    have_left <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/asp_tx_lane.sv
// Capture serialiser: sends the capture sample of the current slot MSB first,
// left-aligned or I2S, and updates its output after each falling bick.
// Assumes: positions from asp_frame_timer; WORD_W < SLOT_W.
module asp_tx_lane #(
    parameter int WORD_W = 24,
    parameter int SLOT_W = 32,
    localparam int PW = $clog2(SLOT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bick_fall,
    input  logic [PW-1:0]     pos,
    input  logic              lrck,
    input  logic              i2s,
    input  logic [WORD_W-1:0] cap_left,
    input  logic [WORD_W-1:0] cap_right,
    output logic              bit_q
);
    localparam logic [PW:0] LEN = (PW+1)'(WORD_W);

    logic [WORD_W-1:0] hold_q, live, word, shl;
    logic [PW:0]       pos_x, first, off;
    logic              in_win, bit_nxt;

    // Pick the slot word and the bit for the coming position
    always_comb begin
        pos_x   = {1'b0, pos};
        live    = ((i2s ? ~lrck : lrck)) ? cap_left : cap_right;
        word    = (pos == '0) ? live : hold_q;
        first   = i2s ? (PW+1)'(1) : '0;
        off     = pos_x - first;
        in_win  = (pos_x >= first) && (off < LEN);
        shl     = word << off;
        bit_nxt = in_win & shl[WORD_W-1];
    end

    // Drive the next bit after a falling bick and latch the word at slot start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            bit_q  <= 1'b0;
        end else if (bick_fall) begin
            bit_q <= bit_nxt;
            if (pos == '0) hold_q <= live;
        end
    end
endmodule

// File: rtl/audio_serial_port.sv
// Top of the slave audio serial port: shared frame timing, NUM_LANES playback
// lanes, one capture serialiser and the output source select.
// Assumes: the external master supplies bick/lrck with SLOT_W bits per slot.
module audio_serial_port #(
    parameter int NUM_LANES = 3,
    parameter int WORD_W    = 24,
    parameter int SHORT_W   = 20,
    parameter int SLOT_W    = 32,
    localparam int PW = $clog2(SLOT_W)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bick,
    input  logic                          lrck,
    input  logic [1:0]                    play_fmt,
    input  logic                          cap_fmt,
    input  logic                          src_sel,
    input  logic [NUM_LANES-1:0]          sdin,
    input  logic                          aux_in,
    input  logic [WORD_W-1:0]             cap_left,
    input  logic [WORD_W-1:0]             cap_right,
    output logic                          sdout,
    output logic [NUM_LANES*WORD_W-1:0]   play_left,
    output logic [NUM_LANES*WORD_W-1:0]   play_right,
    output logic [NUM_LANES-1:0]          play_valid
);
    logic          bick_rise, bick_fall, tx_bit;
    logic [PW-1:0] pos;

    asp_frame_timer #(.SLOT_W(SLOT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bick      (bick),
        .lrck      (lrck),
        .bick_rise (bick_rise),
        .bick_fall (bick_fall),
        .pos       (pos)
    );

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        asp_rx_lane #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .SLOT_W(SLOT_W)) u_rx (
            .clk       (clk),
            .rst_n     (rst_n),
            .bick_rise (bick_rise),
            .pos       (pos),
            .lrck      (lrck),
            .fmt       (asp_pkg::play_fmt_e'(play_fmt)),
            .sdin      (sdin[k]),
            .left_q    (play_left[k*WORD_W +: WORD_W]),
            .right_q   (play_right[k*WORD_W +: WORD_W]),
            .valid_q   (play_valid[k])
        );
    end

    asp_tx_lane #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bick_fall (bick_fall),
        .pos       (pos),
        .lrck      (lrck),
        .i2s       (cap_fmt),
        .cap_left  (cap_left),
        .cap_right (cap_right),
        .bit_q     (tx_bit)
    );

    // Output lane: auxiliary pass-through or internal capture stream
    assign sdout = src_sel ? aux_in : tx_bit;
endmodule

// File: rtl/asp_checker.sv
// Assertion checker for audio_serial_port, attached by bind.
// Assumes: the port encodings given in the block requirements.
module asp_checker #(
    parameter int NUM_LANES = 3,
    parameter int WORD_W    = 24,
    parameter int SHORT_W   = 20,
    localparam int HW = WORD_W - SHORT_W + 1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bick,
    input logic                        src_sel,
    input logic [1:0]                  play_fmt,
    input logic                        sdout,
    input logic [NUM_LANES*WORD_W-1:0] play_left,
    input logic [NUM_LANES*WORD_W-1:0] play_right,
    input logic [NUM_LANES-1:0]        play_valid
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (play_valid == '0 && play_left == '0 &&
                           play_right == '0 && (src_sel || !sdout)));

    // R8
    sdout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_sel && !$fell(bick)) |=> (src_sel || $stable(sdout)));

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_chk
        logic [HW-1:0] top_bits;
        assign top_bits = play_right[k*WORD_W + SHORT_W - 1 +: HW];

        // R6
        valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            play_valid[k] |=> !play_valid[k]);

        // R6
        valid_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            play_valid[k] |-> ($past(bick) && !$past(bick, 2)));

        // R5
        short_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (play_valid[k] && play_fmt == 2'd1) |-> (top_bits == '0 || top_bits == '1));
    end
endmodule

bind audio_serial_port asp_checker #(
    .NUM_LANES (NUM_LANES),
    .WORD_W    (WORD_W),
    .SHORT_W   (SHORT_W)
) u_asp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bick       (bick),
    .src_sel    (src_sel),
    .play_fmt   (play_fmt),
    .sdout      (sdout),
    .play_left  (play_left),
    .play_right (play_right),
    .play_valid (play_valid)
);

// File: tb/tb_audio_serial_port.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module tb_audio_serial_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bick = 1'b0;
    logic        lrck = 1'b0;
    logic [1:0]  play_fmt = 2'd0;
    logic        cap_fmt = 1'b0;
    logic        src_sel = 1'b0;
    logic [2:0]  sdin = '0;
    logic        aux_in = 1'b0;
    logic [23:0] cap_left = '0;
    logic [23:0] cap_right = '0;
    logic        sdout;
    logic [71:0] play_left, play_right;
    logic [2:0]  play_valid;

    int tests = 0;
    int fails = 0;
    int aux_err = 0;
    int chg_p = -1;
    logic [23:0] chg_val = '0;
    int vcnt [3] = '{0, 0, 0};
    logic [23:0] lw [3];
    logic [23:0] rw [3];
    bit done = 0;

    audio_serial_port dut (
        .clk(clk), .rst_n(rst_n), .bick(bick), .lrck(lrck),
        .play_fmt(play_fmt), .cap_fmt(cap_fmt), .src_sel(src_sel),
        .sdin(sdin), .aux_in(aux_in), .cap_left(cap_left), .cap_right(cap_right),
        .sdout(sdout), .play_left(play_left), .play_right(play_right),
        .play_valid(play_valid)
    );

    always #2 clk = ~clk;

    // {play_fmt, cap_fmt, left, right, cap_left, cap_right}
    localparam logic [98:0] VEC [0:5] = '{
        {2'd0, 1'b0, 24'hA5C3F1, 24'h123456, 24'h9ABCDE, 24'h0F0F0F},
        {2'd3, 1'b1, 24'h800001, 24'h7FFFFE, 24'hC00003, 24'h3FFFFC},
        {2'd2, 1'b0, 24'h13579B, 24'hECA864, 24'hFFFFFF, 24'h000001},
        {2'd1, 1'b1, 24'h0ABCDE, 24'hF12345, 24'h800000, 24'h000001},
        {2'd1, 1'b0, 24'hFF8000, 24'h07FFFF, 24'h5A5A5A, 24'hA5A5A5},
        {2'd3, 1'b0, 24'h000000, 24'hFFFFFF, 24'h7FFFFF, 24'h800000}
    };

    always @(negedge clk)
        for (int k = 0; k < 3; k++)
            if (rst_n && play_valid[k]) vcnt[k]++;

    function automatic logic rx_bit(input logic [1:0] f, input logic [23:0] w, input int p);
        case (f)
            2'd0:    return (p < 24) ? w[23-p] : 1'b0;
            2'd3:    return (p >= 1 && p <= 24) ? w[24-p] : 1'b0;
            2'd2:    return (p >= 8) ? w[31-p] : 1'b0;
            default: return (p >= 12) ? w[31-p] : 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] tx_stream(input logic cf, input logic [23:0] w);
        logic [31:0] s;
        for (int p = 0; p < 32; p++) s[31-p] = rx_bit(cf ? 2'd3 : 2'd0, w, p);
        return s;
    endfunction

    function automatic logic [23:0] rx_expect(input logic [1:0] f, input logic [23:0] w);
        return (f == 2'd1) ? {{4{w[19]}}, w[19:0]} : w;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_half(input logic lvl, output logic [31:0] got);
        logic rx_left;
        rx_left = (play_fmt == 2'd3) ? ~lvl : lvl;
        for (int p = 0; p < 32; p++) begin
            @(negedge clk);
            bick = 1'b0;
            if (p == 0) lrck = lvl;
            for (int k = 0; k < 3; k++) sdin[k] = rx_bit(play_fmt, rx_left ? lw[k] : rw[k], p);
            if (lvl && p == chg_p) cap_left = chg_val;
            aux_in = p[0] ^ p[3] ^ lvl;
            repeat (3) @(negedge clk);
            got[31-p] = sdout;
            if (src_sel && sdout !== aux_in) aux_err++;
            @(negedge clk);
            bick = 1'b1;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic do_frame(output logic [31:0] g1, output logic [31:0] g2, output logic first_lvl);
        first_lvl = (play_fmt == 2'd3) ? 1'b0 : 1'b1;
        run_half(first_lvl, g1);
        run_half(~first_lvl, g2);
    endtask

    function automatic logic [63:0] tx_frame(input logic cf, input logic lvl,
                                             input logic [23:0] cl, input logic [23:0] cr);
        logic l1, l2;
        l1 = cf ? ~lvl : lvl;
        l2 = ~l1;
        return {tx_stream(cf, l1 ? cl : cr), tx_stream(cf, l2 ? cl : cr)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] g1, g2;
        logic        lvl;
        logic [98:0] v;
        int          snap [3];
        string       ptag;
        logic [23:0] keep;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset state at the ports
        chk("R1 play_left", 64'(play_left), 64'd0);
        chk("R1 play_right", 64'(play_right), 64'd0);
        chk("R1 valid", 64'(play_valid), 64'd0);
        chk("R1 sdout", 64'(sdout), 64'd0);

        for (int i = 0; i < 6; i++) begin
            v = VEC[i];
            play_fmt  = v[98:97];
            cap_fmt   = v[96];
            cap_left  = v[47:24];
            cap_right = v[23:0];
            for (int k = 0; k < 3; k++) begin
                lw[k] = v[95:72] ^ (24'(k) * 24'h13579B);
                rw[k] = v[71:48] ^ (24'(k) * 24'h13579B);
            end
            case (play_fmt)
                2'd0: ptag = "R2";
                2'd1: ptag = "R5";
                2'd2: ptag = "R4";
                default: ptag = "R3";
            endcase
            do_frame(g1, g2, lvl);
            snap = vcnt;
            do_frame(g1, g2, lvl);
            for (int k = 0; k < 3; k++) begin
                chk($sformatf("%s/R7 lane%0d left vec%0d", ptag, k, i),
                    64'(play_left[k*24 +: 24]), 64'(rx_expect(play_fmt, lw[k])));
                chk($sformatf("%s/R7 lane%0d right vec%0d", ptag, k, i),
                    64'(play_right[k*24 +: 24]), 64'(rx_expect(play_fmt, rw[k])));
                chk($sformatf("R6 lane%0d strobe count vec%0d", k, i),
                    64'(vcnt[k] - snap[k]), 64'd1);
            end
            chk($sformatf("%s capture stream vec%0d", cap_fmt ? "R9" : "R8", i),
                {g1, g2}, tx_frame(cap_fmt, lvl, cap_left, cap_right));
        end

        // R10: capture word changed mid-slot must not alter that slot
        play_fmt = 2'd0; cap_fmt = 1'b0;
        cap_left = 24'hC3A5F0; cap_right = 24'h3C5A0F;
        keep = cap_left;
        do_frame(g1, g2, lvl);
        chg_p = 5; chg_val = 24'h0F0F0F;
        do_frame(g1, g2, lvl);
        chg_p = -1;
        chk("R10 mid-slot change", {g1, g2}, tx_frame(1'b0, lvl, keep, 24'h3C5A0F));
        do_frame(g1, g2, lvl);
        chk("R10 new word next slot", {g1, g2}, tx_frame(1'b0, lvl, 24'h0F0F0F, 24'h3C5A0F));

        // R11: auxiliary pass-through, then return to internal stream
        src_sel = 1'b1; aux_err = 0;
        do_frame(g1, g2, lvl);
        chk("R11 aux mismatches", 64'(aux_err), 64'd0);
        src_sel = 1'b0;
        cap_fmt = 1'b1;
        do_frame(g1, g2, lvl);
        do_frame(g1, g2, lvl);
        chk("R11 internal stream restored", {g1, g2}, tx_frame(1'b1, lvl, cap_left, cap_right));

        // R1: reset in mid-operation clears the stored samples
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 left after reset", 64'(play_left), 64'd0);
        chk("R1 right after reset", 64'(play_right), 64'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule